// File: doc/BRIEF.md
# Third-Order Self-Dithered Digital Delta-Sigma Modulator

This block turns a static 16-bit fraction into a stream of small signed integers whose long-run average equals the fraction divided by 2^16. A fractional-N divider adds the stream to its integer modulus. The loop is a single third-order error-feedback structure. Its quantization noise is shaped by (1-z^-1)^3 and its input reaches the output three cycles late.

Spurious tones are broken up without a pseudo-random generator. The top bit of the modulator's own quantization error is held for one cycle and fed back as a one-bit carry into one of the loop adders. Feeding it into the first stage adds the bit to the signal path without shaping. Feeding it as a +/- pair across the first two stages shapes it by (1-z^-1). A fourth mode injects a dither bit supplied from outside the block.

Top module: `dsm3_sd_mod`

## Requirements
- R1: While rst_ni is low, y_o is 0 and all loop state and the held dither bit are cleared. y_o stays 0 on the first three enabled cycles after reset ends, for any input below 2^16.
- R2: With dither mode 0 (off), let s be the signed loop word that enters the quantizer. Then y_o = floor(s / 2^16) and E = s mod 2^16, and on every enabled cycle s[n] = x[n-3] + 3E[n-1] - 3E[n-2] + E[n-3]. This gives 2^16·Y = z^-3·X - (1-z^-1)^3·E.
- R3: For every input from 0 to 65535 and every dither mode, y_o stays between -3 and +4. This is inside the 4-bit two's-complement range.
- R4: The self-dither bit d[n] is bit 15 of E[n-1], taken on the previous enabled cycle. It is 0 after reset.
- R5: Dither mode 1 (unshaped) adds d to the first-stage adder, which adds d[n-3] to s[n].
- R6: Dither mode 2 (shaped) subtracts d in the first-stage adder and adds d in the second-stage adder, which adds d[n-2] - d[n-3] to s[n].
- R7: Dither mode 3 (external) adds ext_dith_i to the first-stage adder, which adds ext[n-3] to s[n].
- R8: In dither mode 0, no carry is injected, and ext_dith_i has no effect on y_o.
- R9: While en_i is low, no loop state advances and y_o holds its value.
- R10: With a constant input x in mode 0, the sum of y_o over N consecutive enabled cycles is within 9 of N·x/2^16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Advance the loop by one step |
| frac_i | input | 16 | Unsigned fractional input x |
| mode_i | input | 2 | Dither mode: 0 off, 1 unshaped, 2 shaped, 3 external |
| ext_dith_i | input | 1 | Dither bit used in mode 3 |
| y_o | output | 4 | Signed integer output |

## Verification
The embedded properties check these on every cycle: the output bound, that the upper loop bits agree with the 4-bit output, the hold under a low enable, and how the carry injection follows each mode from the previous error MSB or the external bit. Only the bench scenarios can show that the whole loop obeys the third-order difference equation in every mode, that the reset start-up sequence is correct, and that the long-run mean converges to x/2^16. The bench uses a direct-form reference built from the requirement equations and compares it cycle by cycle.

// File: rtl/dsm3_pkg.sv
`timescale 1ns/1ps
package dsm3_pkg;
  typedef enum logic [1:0] {
    DITH_OFF      = 2'd0,
    DITH_UNSHAPED = 2'd1,
    DITH_SHAPED   = 2'd2,
    DITH_EXT      = 2'd3
  } dith_mode_e;
endpackage

// File: rtl/dsm3_quant.sv
`timescale 1ns/1ps
module dsm3_quant #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 4
) (
  input  logic        [IN_W+OUT_W-1:0] q_in_i,
  output logic        [IN_W-1:0]       err_o,
  output logic signed [OUT_W-1:0]      y_o
);
  // floor division by 2^IN_W: upper bits are the integer, lower bits the error
  assign err_o = q_in_i[IN_W-1:0];
  assign y_o   = $signed(q_in_i[IN_W+OUT_W-1:IN_W]);
endmodule

// File: rtl/dsm3_dither.sv
`timescale 1ns/1ps
module dsm3_dither
  import dsm3_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  dith_mode_e        mode_i,
  input  logic              err_msb_i,
  input  logic              ext_dith_i,
  output logic signed [1:0] cin1_o,
  output logic signed [1:0] cin2_o
);
  logic dn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   dn_q <= 1'b0;
    else if (en_i) dn_q <= err_msb_i;
  end

  always_comb begin
    cin1_o = 2'sd0;
    cin2_o = 2'sd0;
    unique case (mode_i)
      DITH_UNSHAPED: cin1_o = {1'b0, dn_q};
      DITH_SHAPED: begin
        // -d into stage 0, +d into stage 1: (1-z^-1) shaping
        cin1_o = dn_q ? -2'sd1 : 2'sd0;
        cin2_o = {1'b0, dn_q};
      end
      DITH_EXT:      cin1_o = {1'b0, ext_dith_i};
      default: ;
    endcase
  end
endmodule

// File: rtl/dsm3_err_loop.sv
`timescale 1ns/1ps
module dsm3_err_loop #(
  parameter int IN_W    = 16,
  parameter int GUARD_W = 5,
  parameter int N_STG   = 3
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            en_i,
  input  logic        [IN_W-1:0]          frac_i,
  input  logic        [IN_W-1:0]          err_i,
  input  logic signed [1:0]               cin1_i,
  input  logic signed [1:0]               cin2_i,
  output logic signed [IN_W+GUARD_W-1:0]  acc_o
);
  localparam int ACC_W = IN_W + GUARD_W;

  logic signed [ACC_W-1:0] err_s, err_x3, frac_s;
  logic signed [ACC_W-1:0] stg_q   [N_STG];
  logic signed [ACC_W-1:0] stg_nxt [N_STG];

  assign err_s  = $signed({{GUARD_W{1'b0}}, err_i});
  assign err_x3 = (err_s <<< 1) + err_s;
  assign frac_s = $signed({{GUARD_W{1'b0}}, frac_i});

  // transposed FIR on E: taps z^-3 (+1), z^-2 (-3), z^-1 (+3)
  for (genvar k = 0; k < N_STG; k++) begin : g_stg
    if (k == 0) begin : g_first
      assign stg_nxt[k] = frac_s + err_s + {{(ACC_W-2){cin1_i[1]}}, cin1_i};
    end else if (k == 1) begin : g_mid
      assign stg_nxt[k] = stg_q[k-1] - err_x3 + {{(ACC_W-2){cin2_i[1]}}, cin2_i};
    end else begin : g_last
      assign stg_nxt[k] = stg_q[k-1] + err_x3;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   stg_q[k] <= '0;
      else if (en_i) stg_q[k] <= stg_nxt[k];
    end
  end

  assign acc_o = stg_q[N_STG-1];
endmodule

// File: rtl/dsm3_sd_mod.sv
`timescale 1ns/1ps
module dsm3_sd_mod
  import dsm3_pkg::*;
#(
  parameter int IN_W    = 16,
  parameter int OUT_W   = 4,
  parameter int GUARD_W = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic [IN_W-1:0]         frac_i,
  input  logic [1:0]              mode_i,
  input  logic                    ext_dith_i,
  output logic signed [OUT_W-1:0] y_o
);
  localparam int ACC_W = IN_W + GUARD_W;
  localparam int HI_W  = ACC_W - (IN_W + OUT_W) + 1;

  dith_mode_e              mode;
  logic signed [ACC_W-1:0] acc;
  logic        [IN_W-1:0]  err;
  logic signed [1:0]       cin1, cin2;
  logic        [HI_W-1:0]  hi_bits;

  assign mode    = dith_mode_e'(mode_i);
  assign hi_bits = acc[ACC_W-1:IN_W+OUT_W-1];

  dsm3_err_loop #(.IN_W(IN_W), .GUARD_W(GUARD_W), .N_STG(3)) u_loop (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .frac_i (frac_i),
    .err_i  (err),
    .cin1_i (cin1),
    .cin2_i (cin2),
    .acc_o  (acc)
  );

  dsm3_quant #(.IN_W(IN_W), .OUT_W(OUT_W)) u_quant (
    .q_in_i (acc[IN_W+OUT_W-1:0]),
    .err_o  (err),
    .y_o    (y_o)
  );

  dsm3_dither u_dith (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .mode_i     (mode),
    .err_msb_i  (err[IN_W-1]),
    .ext_dith_i (ext_dith_i),
    .cin1_o     (cin1),
    .cin2_o     (cin2)
  );

  AST_OUT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (y_o >= -3) && (y_o <= 4)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&hi_bits) || !(|hi_bits)); // R3
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(y_o) && $stable(err)); // R9
  AST_UNSHAPED_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && mode == DITH_UNSHAPED) |-> cin1 == {1'b0, $past(err[IN_W-1])}); // R4
  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode == DITH_OFF |-> cin1 == 2'sd0 && cin2 == 2'sd0); // R8
  AST_SHAPED_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode == DITH_SHAPED |-> (cin1 + cin2) == 2'sd0 && cin2 >= 2'sd0); // R6
  AST_EXT_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode == DITH_EXT |-> cin1 == {1'b0, ext_dith_i} && cin2 == 2'sd0); // R7
endmodule

// File: tb/dsm3_sd_mod_tb_top.sv
`timescale 1ns/1ps
module dsm3_sd_mod_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] frac = '0;
  logic [1:0]  mode = 2'd0;
  logic        ext = 1'b0;
  logic signed [3:0] y;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dsm3_sd_mod dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .frac_i(frac),
    .mode_i(mode), .ext_dith_i(ext), .y_o(y)
  );

  // direct-form reference from the requirement equations
  longint eh1, eh2, eh3, xh1, xh2, xh3;
  longint c1h1, c1h2, c1h3, c2h1, c2h2;
  bit     dcur;

  function automatic longint ref_s();
    return xh3 + c1h3 + c2h2 + 3*eh1 - 3*eh2 + eh3;
  endfunction

  function automatic longint ref_y();
    return ref_s() >>> 16;
  endfunction

  task automatic ref_reset();
    eh1 = 0; eh2 = 0; eh3 = 0; xh1 = 0; xh2 = 0; xh3 = 0;
    c1h1 = 0; c1h2 = 0; c1h3 = 0; c2h1 = 0; c2h2 = 0; dcur = 0;
  endtask

  task automatic ref_step();
    longint e, c1, c2;
    e = ref_s() & 64'hFFFF;
    c1 = 0; c2 = 0;
    case (mode)
      2'd1: c1 = dcur;
      2'd2: begin c1 = -longint'(dcur); c2 = dcur; end
      2'd3: c1 = ext;
      default: ;
    endcase
    eh3 = eh2; eh2 = eh1; eh1 = e;
    xh3 = xh2; xh2 = xh1; xh1 = frac;
    c1h3 = c1h2; c1h2 = c1h1; c1h1 = c1;
    c2h2 = c2h1; c2h1 = c2;
    dcur = e[15];
  endtask

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock with current inputs; compares against the reference at negedge
  task automatic step(string req);
    @(posedge clk);
    if (en) ref_step();
    @(negedge clk);
    check(req, longint'(y), ref_y());
    if (y < -3 || y > 4) check("R3", longint'(y), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ref_reset();
    #20;
    check("R1", longint'(y), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_start();
    mode = 2'd0; frac = 16'd60000; en = 1'b1;
    do_reset();
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); ref_step(); @(negedge clk);
      check("R1", longint'(y), 0);
    end
  endtask

  task automatic t_run(string req, logic [1:0] m, logic [15:0] x, int n);
    mode = m; frac = x; en = 1'b1;
    do_reset();
    for (int i = 0; i < n; i++) begin
      ext = (m == 2'd3 || m == 2'd0) ? ((i % 3) == 0) : 1'b0;
      step(req);
    end
    ext = 1'b0;
  endtask

  task automatic t_hold();
    logic signed [3:0] held;
    mode = 2'd1; frac = 16'd40000; en = 1'b1;
    do_reset();
    for (int i = 0; i < 37; i++) step("R9");
    held = y;
    en = 1'b0;
    for (int i = 0; i < 6; i++) begin
      frac = 16'(i * 9000); ext = i[0];
      @(posedge clk); @(negedge clk);
      check("R9", longint'(y), longint'(held));
    end
    frac = 16'd40000; en = 1'b1;
    for (int i = 0; i < 40; i++) step("R9");
  endtask

  task automatic t_mean(logic [1:0] m, logic [15:0] x, int n);
    longint sum, tgt, diff;
    mode = m; frac = x; en = 1'b1;
    do_reset();
    for (int i = 0; i < 8; i++) step("R10");
    sum = 0;
    for (int i = 0; i < n; i++) begin
      step("R10");
      sum += longint'(y);
    end
    tgt = (longint'(n) * longint'(x)) >>> 16;
    diff = sum - tgt;
    if (diff < 0) diff = -diff;
    check("R10", (diff <= 9) ? 1 : 0, 1);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    ref_reset();
    #13;
    check("R1", longint'(y), 0);
    t_reset_start();
    t_run("R2", 2'd0, 16'd1024, 600);
    t_run("R2", 2'd0, 16'd65535, 600);
    t_run("R2", 2'd0, 16'd0, 100);
    t_run("R2", 2'd0, 16'd21845, 600);
    t_run("R8", 2'd0, 16'd777, 300);
    t_run("R5", 2'd1, 16'd1024, 800);
    t_run("R4", 2'd1, 16'd65535, 400);
    t_run("R6", 2'd2, 16'd1024, 800);
    t_run("R6", 2'd2, 16'd0, 300);
    t_run("R7", 2'd3, 16'd3000, 600);
    t_run("R3", 2'd2, 16'd65535, 600);
    t_hold();
    t_mean(2'd0, 16'd21845, 16384);
    t_mean(2'd0, 16'd64, 16384);
    t_mean(2'd0, 16'd65000, 8192);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule